// File: doc/BRIEF.md
# Control-Flow Next-PC and Stack Unit

This unit resolves every control-transfer instruction of a 32-bit-word instruction set. It produces the next program counter, any memory store of a return address, and the new value of the register that acts as a stack pointer. It takes the raw instruction word and the address of that instruction. It also takes the values of the registers named in the word's register fields, and data returned by a memory read port. It decodes the word itself and works out the branch outcome. Results appear one clock after the instruction is presented. Instruction fetch and the register file stay outside the block. The register file reads the fields and applies the update that the unit reports.

There is no dedicated flags register. Conditional jumps test condition bits held in an ordinary register named by the instruction. The stack pointer is likewise whichever general register the instruction names. Stack pushes store first and then advance the pointer by the register width in bytes. Pops read first and then step the pointer back. The return address that is stored is always the sequential address, which is the instruction address plus 4.

Top module: `ctlflow_unit`

## Requirements
- R1: While reset is active and after its release, out_valid, illegal, mem_we and reg_we are low and next_pc is zero until the first instruction is accepted.
- R2: An instruction presented with in_valid high at a clock edge has its results on the outputs after that edge, with out_valid high for exactly that cycle. Without in_valid, out_valid, mem_we, reg_we and illegal stay low.
- R3: A word with top byte 0x2C is a conditional jump. Bits [23:20] hold the condition and bits [19:16] name the register holding the flags, whose value is on ra_val. In that flag value, bit0 is less-than, bit1 equal, bit2 greater-than, bit3 carry, bit4 borrow and bit5 overflow. Conditions 0..8 test carry, borrow, overflow, greater, greater-or-equal, equal, not-equal, less-or-equal and less. If the jump is taken, next_pc is pc_in plus the sign-extended bits [15:0]; otherwise it is pc_in + 4.
- R4: Greater-or-equal (4) holds when greater-than or equal is set, and less-or-equal (7) holds when less-than or equal is set. Condition 9 is taken when the whole flag register is zero, and condition 0xA when any bit of it is set.
- R5: Condition values 0xB to 0xF set illegal, give next_pc = pc_in + 4, and cause no memory or register write.
- R6: A word with bits [31:16] = 0x3C00 always gives next_pc = pc_in plus the sign-extended bits [15:0].
- R7: CALL (bits [31:8] = 0x090101, register a in [7:4], b in [3:0]) stores pc_in + 4 at address rb_val. It reports register b updated to rb_val + 4 and gives next_pc = ra_val.
- R8: BRANCH (bits [31:8] = 0x090100) stores pc_in + 4 at address rb_val and gives next_pc = ra_val, with no register write.
- R9: The immediate call (bits [31:20] = 0x2D0, register a in [19:16]) stores pc_in + 4 at address ra_val. It reports register a updated to ra_val + 4 and gives next_pc = pc_in plus the sign-extended bits [15:0].
- R10: RET (bits [31:4] = 0x0D01001) and POPPC (bits [31:4] = 0x0D02001), with register a in [3:0], raise mem_re combinationally in the cycle they are presented, with mem_raddr = ra_val. They give next_pc = mem_rdata of that cycle and report register a updated to ra_val - 4, with no store.
- R11: PUSHPC (bits [31:4] = 0x0D02000, register a in [3:0]) stores pc_in + 4 at address ra_val. It reports register a updated to ra_val + 4 and gives next_pc = pc_in + 4.
- R12: Any other word, including near-misses of the encodings above, gives next_pc = pc_in + 4, with no write and illegal low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Raw instruction word |
| pc_in | input | XLEN | Address of the presented instruction |
| ra_val | input | XLEN | Value of the register in field a |
| rb_val | input | XLEN | Value of the register in field b |
| mem_rdata | input | XLEN | Data returned for mem_raddr in the same cycle |
| mem_re | output | 1 | Stack read request (combinational) |
| mem_raddr | output | XLEN | Stack read address (combinational) |
| out_valid | output | 1 | Results of the previous cycle's instruction are valid |
| next_pc | output | XLEN | Resolved next program counter |
| illegal | output | 1 | Reserved condition code was seen |
| mem_we | output | 1 | Store of a return address |
| mem_waddr | output | XLEN | Store address |
| mem_wdata | output | XLEN | Stored return address |
| reg_we | output | 1 | Stack-pointer register update |
| reg_idx | output | 4 | Index of the register to update |
| reg_data | output | XLEN | New stack-pointer value |

## Verification
A wrong decode or a wrong flag test shows up in the very next cycle. It appears as a wrong next_pc, or as a store or pointer update strobe where none belongs, because nothing is held across instructions except the one output stage. A wrong pointer step shows up in reg_data in that same cycle. Back-to-back instructions, a wrapping pointer and the most negative offset are therefore enough to expose it. A stuck strobe or a stuck valid shows up in the first idle cycle that follows.

// File: rtl/ctlflow_pkg.sv
package ctlflow_pkg;

  typedef enum logic [3:0] {
    CF_NONE,
    CF_JCC,
    CF_JMP,
    CF_BRANCH,
    CF_CALL,
    CF_CALLI,
    CF_RET,
    CF_POPPC,
    CF_PUSHPC
  } cf_op_e;

  localparam int INSN_W = 32;
  localparam int IMM_W  = 16;
  localparam int RIDX_W = 4;

  // leading opcode bytes
  localparam logic [7:0] OPC_JCC   = 8'h2C;
  localparam logic [7:0] OPC_JMP   = 8'h3C;
  localparam logic [7:0] OPC_ICALL = 8'h2D;
  localparam logic [7:0] OPC_REG2  = 8'h09;
  localparam logic [7:0] OPC_REG1  = 8'h0D;

  // condition selector values
  localparam logic [3:0] CC_CARRY   = 4'h0;
  localparam logic [3:0] CC_BORROW  = 4'h1;
  localparam logic [3:0] CC_OVF     = 4'h2;
  localparam logic [3:0] CC_GT      = 4'h3;
  localparam logic [3:0] CC_GE      = 4'h4;
  localparam logic [3:0] CC_EQ      = 4'h5;
  localparam logic [3:0] CC_NE      = 4'h6;
  localparam logic [3:0] CC_LE      = 4'h7;
  localparam logic [3:0] CC_LT      = 4'h8;
  localparam logic [3:0] CC_ZERO    = 4'h9;
  localparam logic [3:0] CC_NONZERO = 4'hA;

  // bit positions inside the condition register
  localparam int FB_LT  = 0;
  localparam int FB_EQ  = 1;
  localparam int FB_GT  = 2;
  localparam int FB_CY  = 3;
  localparam int FB_BR  = 4;
  localparam int FB_OV  = 5;

endpackage

// File: rtl/cf_decode.sv
module cf_decode
  import ctlflow_pkg::*;
(
  input  logic [INSN_W-1:0] instr,
  output cf_op_e            op,
  output logic [3:0]        cond,
  output logic [IMM_W-1:0]  imm,
  output logic [RIDX_W-1:0] sp_idx
);

  logic [7:0]  major;
  logic [15:0] xop_mid;

  assign major   = instr[31:24];
  assign xop_mid = instr[23:8];
  assign cond    = instr[23:20];
  assign imm     = instr[IMM_W-1:0];

  always_comb begin
    op     = CF_NONE;
    sp_idx = instr[19:16];
    unique case (major)
      OPC_JCC: begin
        op = CF_JCC;
      end
      OPC_JMP: begin
        if (instr[23:16] == 8'h00) op = CF_JMP;
      end
      OPC_ICALL: begin
        if (instr[23:20] == 4'h0) op = CF_CALLI;
      end
      OPC_REG2: begin
        sp_idx = instr[3:0];
        if (xop_mid == 16'h0100)      op = CF_BRANCH;
        else if (xop_mid == 16'h0101) op = CF_CALL;
      end
      OPC_REG1: begin
        sp_idx = instr[3:0];
        if (xop_mid == 16'h0100 && instr[7:4] == 4'h1)      op = CF_RET;
        else if (xop_mid == 16'h0200 && instr[7:4] == 4'h0) op = CF_PUSHPC;
        else if (xop_mid == 16'h0200 && instr[7:4] == 4'h1) op = CF_POPPC;
      end
      default: op = CF_NONE;
    endcase
  end

endmodule

// File: rtl/cf_cond.sv
module cf_cond
  import ctlflow_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] flags,
  input  logic [3:0]      cond,
  output logic            hit,
  output logic            rsvd
);

  logic lt, eq, gt, cy, br, ov, allz;

  assign lt   = flags[FB_LT];
  assign eq   = flags[FB_EQ];
  assign gt   = flags[FB_GT];
  assign cy   = flags[FB_CY];
  assign br   = flags[FB_BR];
  assign ov   = flags[FB_OV];
  assign allz = ~|flags;

  always_comb begin
    hit  = 1'b0;
    rsvd = 1'b0;
    unique case (cond)
      CC_CARRY:   hit = cy;
      CC_BORROW:  hit = br;
      CC_OVF:     hit = ov;
      CC_GT:      hit = gt;
      CC_GE:      hit = gt | eq;
      CC_EQ:      hit = eq;
      CC_NE:      hit = ~eq;
      CC_LE:      hit = lt | eq;
      CC_LT:      hit = lt;
      CC_ZERO:    hit = allz;
      CC_NONZERO: hit = ~allz;
      default:    rsvd = 1'b1;
    endcase
  end

endmodule

// File: rtl/cf_exec.sv
module cf_exec
  import ctlflow_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  cf_op_e           op,
  input  logic             hit,
  input  logic             rsvd,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  pc,
  input  logic [XLEN-1:0]  ra,
  input  logic [XLEN-1:0]  rb,
  input  logic [XLEN-1:0]  rdata,
  output logic [XLEN-1:0]  npc,
  output logic             ill,
  output logic             mwe,
  output logic [XLEN-1:0]  waddr,
  output logic [XLEN-1:0]  wdata,
  output logic             rwe,
  output logic [XLEN-1:0]  rnew,
  output logic             mre
);

  localparam logic [XLEN-1:0] STEP  = XLEN'(INSN_BYTES);
  localparam logic [XLEN-1:0] SPSZ  = XLEN'(XLEN / 8);

  logic [XLEN-1:0] simm;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] rel_pc;

  generate
    if (XLEN > IMM_W) begin : g_sext
      assign simm = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    end else begin : g_trunc
      assign simm = imm[XLEN-1:0];
    end
  endgenerate

  assign seq_pc = pc + STEP;
  assign rel_pc = pc + simm;

  always_comb begin
    npc   = seq_pc;
    ill   = 1'b0;
    mwe   = 1'b0;
    waddr = ra;
    wdata = seq_pc;
    rwe   = 1'b0;
    rnew  = ra + SPSZ;
    mre   = 1'b0;
    unique case (op)
      CF_JCC: begin
        if (rsvd)     ill = 1'b1;
        else if (hit) npc = rel_pc;
      end
      CF_JMP: npc = rel_pc;
      CF_BRANCH: begin
        mwe   = 1'b1;
        waddr = rb;
        npc   = ra;
      end
      CF_CALL: begin
        mwe   = 1'b1;
        waddr = rb;
        rwe   = 1'b1;
        rnew  = rb + SPSZ;
        npc   = ra;
      end
      CF_CALLI: begin
        mwe = 1'b1;
        rwe = 1'b1;
        npc = rel_pc;
      end
      CF_PUSHPC: begin
        mwe = 1'b1;
        rwe = 1'b1;
      end
      CF_RET, CF_POPPC: begin
        mre  = 1'b1;
        rwe  = 1'b1;
        rnew = ra - SPSZ;
        npc  = rdata;
      end
      default: npc = seq_pc;
    endcase
  end

endmodule

// File: rtl/ctlflow_unit.sv
module ctlflow_unit
  import ctlflow_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4,
  parameter int RST_SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] instr,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [XLEN-1:0]   ra_val,
  input  logic [XLEN-1:0]   rb_val,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              mem_re,
  output logic [XLEN-1:0]   mem_raddr,
  output logic              out_valid,
  output logic [XLEN-1:0]   next_pc,
  output logic              illegal,
  output logic              mem_we,
  output logic [XLEN-1:0]   mem_waddr,
  output logic [XLEN-1:0]   mem_wdata,
  output logic              reg_we,
  output logic [RIDX_W-1:0] reg_idx,
  output logic [XLEN-1:0]   reg_data
);

  // reset: asserted asynchronously, released after RST_SYNC edges
  logic [RST_SYNC-1:0] rst_pipe;
  logic                rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_SYNC-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe[RST_SYNC-1];

  // decode and evaluation
  cf_op_e            op;
  logic [3:0]        cond;
  logic [IMM_W-1:0]  imm;
  logic [RIDX_W-1:0] sp_idx;
  logic              hit, rsvd;
  logic [XLEN-1:0]   npc_c, waddr_c, wdata_c, rnew_c;
  logic              ill_c, mwe_c, rwe_c, mre_c;

  cf_decode u_dec (
    .instr  (instr),
    .op     (op),
    .cond   (cond),
    .imm    (imm),
    .sp_idx (sp_idx)
  );

  cf_cond #(.XLEN(XLEN)) u_cond (
    .flags (ra_val),
    .cond  (cond),
    .hit   (hit),
    .rsvd  (rsvd)
  );

  cf_exec #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_exec (
    .op    (op),
    .hit   (hit),
    .rsvd  (rsvd),
    .imm   (imm),
    .pc    (pc_in),
    .ra    (ra_val),
    .rb    (rb_val),
    .rdata (mem_rdata),
    .npc   (npc_c),
    .ill   (ill_c),
    .mwe   (mwe_c),
    .waddr (waddr_c),
    .wdata (wdata_c),
    .rwe   (rwe_c),
    .rnew  (rnew_c),
    .mre   (mre_c)
  );

  assign mem_re    = in_valid & mre_c;
  assign mem_raddr = ra_val;

  // next-state for the output stage
  logic              vld_d, ill_d, mwe_d, rwe_d;
  logic              data_en;

  always_comb begin
    vld_d   = in_valid;
    ill_d   = in_valid & ill_c;
    mwe_d   = in_valid & mwe_c;
    rwe_d   = in_valid & rwe_c;
    data_en = in_valid;
  end

  // output stage: strobes every cycle, data only with an instruction
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      mem_we    <= 1'b0;
      reg_we    <= 1'b0;
    end else begin
      out_valid <= vld_d;
      illegal   <= ill_d;
      mem_we    <= mwe_d;
      reg_we    <= rwe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      next_pc   <= '0;
      mem_waddr <= '0;
      mem_wdata <= '0;
      reg_idx   <= '0;
      reg_data  <= '0;
    end else if (data_en) begin
      next_pc   <= npc_c;
      mem_waddr <= waddr_c;
      mem_wdata <= wdata_c;
      reg_idx   <= sp_idx;
      reg_data  <= rnew_c;
    end
  end

endmodule

// File: rtl/ctlflow_unit_chk.sv
module ctlflow_unit_chk #(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [31:0]     instr,
  input logic [XLEN-1:0] pc_in,
  input logic [XLEN-1:0] mem_rdata,
  input logic            mem_re,
  input logic [XLEN-1:0] mem_raddr,
  input logic            out_valid,
  input logic [XLEN-1:0] next_pc,
  input logic            illegal,
  input logic            mem_we,
  input logic [XLEN-1:0] mem_wdata,
  input logic            reg_we,
  input logic [XLEN-1:0] reg_data
);

  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);
  localparam logic [XLEN-1:0] SPSZ = XLEN'(XLEN / 8);

  logic [XLEN-1:0] simm;
  assign simm = XLEN'($signed(instr[15:0]));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!mem_we && !reg_we && !illegal));

  a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  a_r5_illegal_seq: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (out_valid && !mem_we && !reg_we && next_pc == $past(pc_in) + STEP));

  a_r7_ret_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata == $past(pc_in) + STEP));

  a_r6_jump_rel: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_valid) && $past(instr[31:16]) == 16'h3C00)
      |-> (next_pc == $past(pc_in) + $past(simm)));

  a_r10_read_gate: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> in_valid);

  a_r10_pop_update: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mem_re))
      |-> (reg_we && !mem_we && reg_data == $past(mem_raddr) - SPSZ
           && next_pc == $past(mem_rdata)));

endmodule

bind ctlflow_unit ctlflow_unit_chk #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .instr     (instr),
  .pc_in     (pc_in),
  .mem_rdata (mem_rdata),
  .mem_re    (mem_re),
  .mem_raddr (mem_raddr),
  .out_valid (out_valid),
  .next_pc   (next_pc),
  .illegal   (illegal),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .reg_we    (reg_we),
  .reg_data  (reg_data)
);

// File: tb/ctlflow_unit_tb.sv
`timescale 1ns/1ps
module ctlflow_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] pc_in = '0;
  logic [31:0] ra_val = '0;
  logic [31:0] rb_val = '0;
  logic [31:0] mem_rdata = '0;
  logic        mem_re;
  logic [31:0] mem_raddr;
  logic        out_valid;
  logic [31:0] next_pc;
  logic        illegal;
  logic        mem_we;
  logic [31:0] mem_waddr;
  logic [31:0] mem_wdata;
  logic        reg_we;
  logic [3:0]  reg_idx;
  logic [31:0] reg_data;

  int checks = 0;
  int errors = 0;
  bit mon_on = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ctlflow_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .pc_in(pc_in), .ra_val(ra_val), .rb_val(rb_val), .mem_rdata(mem_rdata),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .out_valid(out_valid),
    .next_pc(next_pc), .illegal(illegal), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .reg_we(reg_we),
    .reg_idx(reg_idx), .reg_data(reg_data)
  );

  typedef struct packed {
    logic [31:0] npc;
    logic        ill;
    logic        mwe;
    logic [31:0] waddr;
    logic [31:0] wdata;
    logic        rwe;
    logic [3:0]  idx;
    logic [31:0] rdat;
    logic        mre;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];

  function automatic exp_t model(input logic [31:0] ins, input logic [31:0] pc,
                                 input logic [31:0] ra, input logic [31:0] rb,
                                 input logic [31:0] rd);
    exp_t e;
    logic [31:0] sx;
    logic t;
    sx = {{16{ins[15]}}, ins[15:0]};
    e = '0;
    e.npc = pc + 32'd4;
    t = 1'b0;
    if (ins[31:24] == 8'h2C) begin
      case (ins[23:20])
        4'h0: t = ra[3];
        4'h1: t = ra[4];
        4'h2: t = ra[5];
        4'h3: t = ra[2];
        4'h4: t = ra[2] | ra[1];
        4'h5: t = ra[1];
        4'h6: t = !ra[1];
        4'h7: t = ra[0] | ra[1];
        4'h8: t = ra[0];
        4'h9: t = (ra == 32'd0);
        4'hA: t = (ra != 32'd0);
        default: e.ill = 1'b1;
      endcase
      if (t) e.npc = pc + sx;
    end else if (ins[31:16] == 16'h3C00) begin
      e.npc = pc + sx;
    end else if (ins[31:8] == 24'h090100 || ins[31:8] == 24'h090101) begin
      e.mwe = 1'b1; e.waddr = rb; e.wdata = pc + 32'd4; e.npc = ra;
      if (ins[8]) begin e.rwe = 1'b1; e.idx = ins[3:0]; e.rdat = rb + 32'd4; end
    end else if (ins[31:20] == 12'h2D0) begin
      e.mwe = 1'b1; e.waddr = ra; e.wdata = pc + 32'd4; e.npc = pc + sx;
      e.rwe = 1'b1; e.idx = ins[19:16]; e.rdat = ra + 32'd4;
    end else if (ins[31:4] == 28'h0D01001 || ins[31:4] == 28'h0D02001) begin
      e.mre = 1'b1; e.npc = rd;
      e.rwe = 1'b1; e.idx = ins[3:0]; e.rdat = ra - 32'd4;
    end else if (ins[31:4] == 28'h0D02000) begin
      e.mwe = 1'b1; e.waddr = ra; e.wdata = pc + 32'd4;
      e.rwe = 1'b1; e.idx = ins[3:0]; e.rdat = ra + 32'd4;
    end
    return e;
  endfunction

  task automatic issue(input logic [31:0] ins, input logic [31:0] pc,
                       input logic [31:0] ra, input logic [31:0] rb,
                       input logic [31:0] rd, input string tag);
    exp_t e;
    e = model(ins, pc, ra, rb, rd);
    @(negedge clk);
    #1;
    in_valid = 1'b1; instr = ins; pc_in = pc;
    ra_val = ra; rb_val = rb; mem_rdata = rd;
    expq.push_back(e);
    tagq.push_back(tag);
    #0.5;
    checks++;
    if (mem_re !== e.mre || (e.mre && mem_raddr !== ra)) begin
      errors++;
      $display("FAIL %s read port: re=%0b addr=%h expected re=%0b addr=%h",
               tag, mem_re, mem_raddr, e.mre, ra);
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    #1;
    in_valid = 1'b0;
    instr = 32'h0D010013;
  endtask

  // monitor: compares each result against the scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        checks++;
        if (expq.size() == 0) begin
          errors++;
          $display("FAIL R2 unexpected out_valid: actual 1 expected 0");
        end else begin
          exp_t e;
          string tg;
          bit bad;
          e = expq.pop_front();
          tg = tagq.pop_front();
          bad = (next_pc !== e.npc) || (illegal !== e.ill) ||
                (mem_we !== e.mwe) || (reg_we !== e.rwe);
          if (e.mwe) bad = bad || (mem_waddr !== e.waddr) || (mem_wdata !== e.wdata);
          if (e.rwe) bad = bad || (reg_idx !== e.idx) || (reg_data !== e.rdat);
          if (bad) begin
            errors++;
            $display("FAIL %s: npc=%h ill=%0b we=%0b wa=%h wd=%h rwe=%0b ri=%0d rd=%h expected npc=%h ill=%0b we=%0b wa=%h wd=%h rwe=%0b ri=%0d rd=%h",
                     tg, next_pc, illegal, mem_we, mem_waddr, mem_wdata, reg_we, reg_idx, reg_data,
                     e.npc, e.ill, e.mwe, e.waddr, e.wdata, e.rwe, e.idx, e.rdat);
          end
        end
      end else begin
        checks++;
        if (mem_we !== 1'b0 || reg_we !== 1'b0 || illegal !== 1'b0) begin
          errors++;
          $display("FAIL R2 idle strobes: we=%0b rwe=%0b ill=%0b expected 0 0 0",
                   mem_we, reg_we, illegal);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    // R1: reset state, held through the release synchroniser
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || illegal !== 1'b0 || mem_we !== 1'b0 ||
        reg_we !== 1'b0 || next_pc !== 32'd0) begin
      errors++;
      $display("FAIL R1 reset: v=%0b ill=%0b we=%0b rwe=%0b npc=%h expected 0 0 0 0 00000000",
               out_valid, illegal, mem_we, reg_we, next_pc);
    end
    mon_on = 1;

    // R3: single-bit conditions, taken and not taken
    issue({8'h2C, 4'h0, 4'h3, 16'h0040}, 32'h1000, 32'h08, 0, 0, "R3 carry taken");
    issue({8'h2C, 4'h0, 4'h3, 16'h0040}, 32'h1000, 32'h37, 0, 0, "R3 carry not taken");
    issue({8'h2C, 4'h1, 4'h3, 16'hFFF0}, 32'h2000, 32'h10, 0, 0, "R3 borrow taken backward");
    issue({8'h2C, 4'h2, 4'h3, 16'h0100}, 32'h2000, 32'h20, 0, 0, "R3 overflow taken");
    issue({8'h2C, 4'h3, 4'h3, 16'h0008}, 32'h3000, 32'h04, 0, 0, "R3 greater taken");
    issue({8'h2C, 4'h3, 4'h3, 16'h0008}, 32'h3000, 32'h02, 0, 0, "R3 greater not taken");
    issue({8'h2C, 4'h5, 4'h3, 16'h0008}, 32'h3000, 32'h02, 0, 0, "R3 equal taken");
    issue({8'h2C, 4'h6, 4'h3, 16'h0008}, 32'h3000, 32'h02, 0, 0, "R3 not-equal not taken");
    issue({8'h2C, 4'h6, 4'h3, 16'h0008}, 32'h3000, 32'h05, 0, 0, "R3 not-equal taken");
    issue({8'h2C, 4'h8, 4'h3, 16'h8000}, 32'h0001_0000, 32'h01, 0, 0, "R3 less taken min offset");
    // R4: compound and whole-register tests
    issue({8'h2C, 4'h4, 4'h3, 16'h0010}, 32'h4000, 32'h02, 0, 0, "R4 ge via equal");
    issue({8'h2C, 4'h4, 4'h3, 16'h0010}, 32'h4000, 32'h01, 0, 0, "R4 ge not with less");
    issue({8'h2C, 4'h7, 4'h3, 16'h0010}, 32'h4000, 32'h01, 0, 0, "R4 le via less");
    issue({8'h2C, 4'h7, 4'h3, 16'h0010}, 32'h4000, 32'h04, 0, 0, "R4 le not with greater");
    issue({8'h2C, 4'h9, 4'h3, 16'h0010}, 32'h4000, 32'h00, 0, 0, "R4 zero taken");
    issue({8'h2C, 4'h9, 4'h3, 16'h0010}, 32'h4000, 32'h100, 0, 0, "R4 zero not taken high bit");
    issue({8'h2C, 4'hA, 4'h3, 16'h0010}, 32'h4000, 32'h100, 0, 0, "R4 nonzero taken high bit");
    // R5: reserved conditions
    issue({8'h2C, 4'hB, 4'h3, 16'h0010}, 32'h5000, 32'hFFFF_FFFF, 0, 0, "R5 reserved B");
    issue({8'h2C, 4'hF, 4'h3, 16'h0010}, 32'h5000, 32'hFFFF_FFFF, 0, 0, "R5 reserved F");
    go_idle();
    // R6: unconditional jump
    issue(32'h3C00_0010, 32'h6000, 0, 0, 0, "R6 jump forward");
    issue(32'h3C00_8000, 32'h0002_0000, 0, 0, 0, "R6 jump min offset");
    // R7 / R8: register call and branch
    issue(32'h0901_0145, 32'h7000, 32'h0000_9000, 32'h0000_0FF0, 0, "R7 call");
    issue(32'h0901_0023, 32'h7100, 32'h0000_A000, 32'h0000_0F00, 0, "R8 branch");
    // R9: immediate call
    issue(32'h2D07_0100, 32'h8000, 32'h0000_0E00, 0, 0, "R9 immediate call");
    issue(32'h2D07_FFFC, 32'h8000, 32'hFFFF_FFFC, 0, 0, "R9 immediate call wrap");
    // R10: return and pop
    issue(32'h0D01_0019, 32'h9000, 32'h0000_0E04, 0, 32'h0000_1234, "R10 return");
    issue(32'h0D02_001C, 32'h9100, 32'h0000_0000, 0, 32'h0000_5678, "R10 pop wrap");
    // R11: push
    issue(32'h0D02_000E, 32'hA000, 32'h0000_0D00, 0, 0, "R11 push");
    go_idle();
    // R12: unrelated and near-miss words
    issue(32'h0500_0123, 32'hB000, 32'h0000_0100, 32'h0000_0200, 0, "R12 arithmetic word");
    issue(32'h3C01_0010, 32'hB000, 0, 0, 0, "R12 jump near-miss");
    issue(32'h2D17_0010, 32'hB000, 32'h0000_0100, 0, 0, "R12 immediate near-miss");
    issue(32'h0901_0223, 32'hB000, 32'h0000_0100, 32'h0000_0200, 0, "R12 call near-miss");
    issue(32'h0D01_0003, 32'hB000, 32'h0000_0100, 0, 32'hDEAD_BEEF, "R12 coroutine word");
    issue(32'hFFFF_FFFF, 32'hB000, 0, 0, 0, "R12 halt word");
    go_idle();
    repeat (3) @(negedge clk);

    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R2 missing results: actual %0d pending expected 0", expq.size());
    end
    finish_run();
  end

endmodule